// File: doc/BRIEF.md
# Video Multiply-Add Datapath

This unit is a single-stage integer datapath for the video-style multiply-add operation of a shader core. It takes two multiplicand operands, A and B. Each one is narrowed to a chosen byte, a chosen halfword or the full word, and is then extended to 32 bits with zero or sign extension. B can come from a 16-bit immediate instead of a register. The unit forms the full 64-bit product, folds in a third operand C, and applies one of four averaging behaviours. It then scales the 64-bit value by a fixed right shift and can saturate the outcome to 32 bits. Condition codes are not produced.

Operations enter through a valid/ready port and leave through a second valid/ready port, one result per operation, in order. The result register is the only storage. An operation is accepted when `in_valid` and `in_ready` are both high at a rising edge. `in_ready` is high whenever the result register is empty or its contents are being taken in the same cycle. A result presented on `out_valid` stays unchanged until `out_ready` takes it. The upstream side must hold all `in_*` fields steady while `in_valid` is high and `in_ready` is low.

Top module: `vmad_unit`

## Requirements
- R1: Select code bits [2:0] pick the operand source. Values 0 to 3 take byte 0 to 3, 4 takes halfword 0 (bits 15:0), 5 takes halfword 1 (bits 31:16), and 6 or 7 take the whole 32-bit word.
- R2: Bit 3 of a select code marks the operand as signed. A signed byte or halfword is sign-extended and an unsigned one is zero-extended. The signed full-word codes are 14 and 15.
- R3: When `in_use_imm` is 1, B is `in_imm`. It is sign-extended when `in_bsel[3]` is 1 and zero-extended otherwise, and `in_b` is ignored.
- R4: The exact 64-bit product of the two extended operands is formed, including the case where one operand is signed and the other is unsigned.
- R5: C is treated as an unsigned 32-bit value. It is added to the low word of the product, and the carry out of that addition goes into the high word.
- R6: `in_mode` selects the averaging behaviour:
  - 0: plain add;
  - 1: C is replaced by its 32-bit two's complement before the add;
  - 2: the 64-bit product is negated before the add;
  - 3: one is added to the 64-bit sum.
- R7: The result is signed when either select code is 14 or 15, or when `in_mode` is 1 or 2. Otherwise it is unsigned.
- R8: `in_scale` sets the right shift of the 64-bit sum: 1 shifts by 7, 2 shifts by 15, and 0 or 3 leave it unshifted. The shift is arithmetic for a signed result and logical for an unsigned one.
- R9: With saturation on and a signed result, an upper word that is not the sign extension of the lower word clamps the output. The output becomes 0x80000000 when the upper word is negative and 0x7FFFFFFF otherwise. Without such overflow the lower word is output.
- R10: With saturation on and an unsigned result, a nonzero upper word yields 0xFFFFFFFF when it is non-negative and 0 when it is negative. Otherwise the lower word is output.
- R11: With saturation off, the output is the lower 32 bits of the scaled sum.
- R12: A result appears on the output one cycle after its operation is accepted. It is held stable while `out_ready` is low, and `in_ready` is high exactly when the output register is empty or is being drained.
- R13: Synchronous reset empties the output register, so `out_valid` is 0 and `in_ready` is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be accepted |
| in_a | input | 32 | Operand A register value |
| in_b | input | 32 | Operand B register value |
| in_c | input | 32 | Addend C |
| in_imm | input | 16 | Immediate for B |
| in_use_imm | input | 1 | Take B from the immediate |
| in_asel | input | 4 | A select code |
| in_bsel | input | 4 | B select code |
| in_mode | input | 2 | Averaging behaviour |
| in_scale | input | 2 | Right-shift scale |
| in_sat | input | 1 | Saturate to 32 bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Result |

## Verification
The assertions take for granted that every operation field carries a known value whenever `in_valid` is high. They also assume that reset is held for at least one rising edge before traffic starts. Every 4-bit select code and every mode and scale value is defined, so no operand encoding is excluded.

The stimulus drives all fields with defined values on every cycle and holds them while an offer is stalled. It sweeps every combination of the two select codes, the mode, the scale, saturation and the immediate choice, using operand sets that include lanes with their sign bits forced high. The output side is stalled at random during the sweep.

// File: rtl/vmad_pkg.sv
package vmad_pkg;

  localparam int unsigned SEL_W = 4;

  typedef enum logic [1:0] {
    AVG_PLAIN    = 2'd0,
    AVG_NEG_C    = 2'd1,
    AVG_NEG_PROD = 2'd2,
    AVG_PLUS_ONE = 2'd3
  } avg_mode_e;

  typedef enum logic [1:0] {
    SCL_NONE   = 2'd0,
    SCL_SHR_LO = 2'd1,
    SCL_SHR_HI = 2'd2,
    SCL_SPARE  = 2'd3
  } scale_e;

  // full-word source with the signed flag
  function automatic logic sel_full_signed(input logic [SEL_W-1:0] s);
    return s[3] & s[2] & s[1];
  endfunction

endpackage

// File: rtl/vmad_operand.sv
module vmad_operand #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] raw,
  input  logic [3:0]   sel,
  output logic [W:0]   ext
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = W / 2;

  logic [BYTE_W-1:0] lane_b;
  logic [HALF_W-1:0] lane_h;
  logic              sgn;

  always_comb begin
    sgn    = sel[3];
    lane_b = raw[{sel[1:0], 3'b000} +: BYTE_W];
    lane_h = sel[0] ? raw[W-1 -: HALF_W] : raw[HALF_W-1:0];
    if (!sel[2]) begin
      ext = {{(W+1-BYTE_W){sgn & lane_b[BYTE_W-1]}}, lane_b};
    end else if (!sel[1]) begin
      ext = {{(W+1-HALF_W){sgn & lane_h[HALF_W-1]}}, lane_h};
    end else begin
      ext = {sgn & raw[W-1], raw};
    end
  end

endmodule

// File: rtl/vmad_product.sv
module vmad_product
  import vmad_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W:0]     a_ext,
  input  logic [W:0]     b_ext,
  input  logic [W-1:0]   c,
  input  logic [1:0]     mode,
  output logic [2*W-1:0] acc
);
  localparam int unsigned PW = 2 * W + 2;

  logic signed [PW-1:0]  a_wide;
  logic signed [PW-1:0]  b_wide;
  logic signed [PW-1:0]  full;
  logic        [2*W-1:0] prod;
  logic        [2*W-1:0] prod_m;
  logic        [W-1:0]   c_m;
  logic        [2*W-1:0] sum;

  always_comb begin
    a_wide = {{(W+1){a_ext[W]}}, a_ext};
    b_wide = {{(W+1){b_ext[W]}}, b_ext};
    full   = a_wide * b_wide;
    prod   = full[2*W-1:0];
    prod_m = (mode == AVG_NEG_PROD) ? (~prod + 1'b1) : prod;
    c_m    = (mode == AVG_NEG_C) ? (~c + 1'b1) : c;
    sum    = prod_m + {{W{1'b0}}, c_m};
    acc    = (mode == AVG_PLUS_ONE) ? (sum + 1'b1) : sum;
  end

endmodule

// File: rtl/vmad_post.sv
module vmad_post
  import vmad_pkg::*;
#(
  parameter int unsigned W    = 32,
  parameter int unsigned SH_A = 7,
  parameter int unsigned SH_B = 15
) (
  input  logic [2*W-1:0] acc,
  input  logic [1:0]     scale,
  input  logic           res_signed,
  input  logic           sat_en,
  output logic [W-1:0]   res
);
  localparam int unsigned AMT_W = $clog2(2 * W);
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MIN = {1'b1, {(W-1){1'b0}}};

  logic [AMT_W-1:0] amt;
  logic [2*W-1:0]   shifted;
  logic [W-1:0]     hi;
  logic [W-1:0]     lo;
  logic             ovf;

  always_comb begin
    case (scale)
      SCL_SHR_LO: amt = AMT_W'(SH_A);
      SCL_SHR_HI: amt = AMT_W'(SH_B);
      default:    amt = '0;
    endcase
    if (res_signed) shifted = $signed(acc) >>> amt;
    else            shifted = acc >> amt;
    hi = shifted[2*W-1:W];
    lo = shifted[W-1:0];
    if (res_signed) ovf = (hi != {W{lo[W-1]}});
    else            ovf = (hi != '0);
    if (!sat_en || !ovf)  res = lo;
    else if (res_signed)  res = hi[W-1] ? NEG_MIN : POS_MAX;
    else                  res = hi[W-1] ? '0 : '1;
  end

endmodule

// File: rtl/vmad_unit.sv
module vmad_unit
  import vmad_pkg::*;
#(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 16,
  parameter int unsigned SH_A  = 7,
  parameter int unsigned SH_B  = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic [W-1:0]     in_c,
  input  logic [IMM_W-1:0] in_imm,
  input  logic             in_use_imm,
  input  logic [3:0]       in_asel,
  input  logic [3:0]       in_bsel,
  input  logic [1:0]       in_mode,
  input  logic [1:0]       in_scale,
  input  logic             in_sat,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     out_data
);
  logic [W:0]     a_ext;
  logic [W:0]     b_reg_ext;
  logic [W:0]     b_ext;
  logic [2*W-1:0] acc;
  logic           res_signed;
  logic [W-1:0]   res;
  logic           take;

  vmad_operand #(.W(W)) u_op_a (.raw(in_a), .sel(in_asel), .ext(a_ext));
  vmad_operand #(.W(W)) u_op_b (.raw(in_b), .sel(in_bsel), .ext(b_reg_ext));

  always_comb begin
    if (in_use_imm)
      b_ext = {{(W+1-IMM_W){in_bsel[3] & in_imm[IMM_W-1]}}, in_imm};
    else
      b_ext = b_reg_ext;
    res_signed = sel_full_signed(in_asel) | sel_full_signed(in_bsel) |
                 (in_mode == AVG_NEG_C) | (in_mode == AVG_NEG_PROD);
  end

  vmad_product #(.W(W)) u_prod (
    .a_ext(a_ext), .b_ext(b_ext), .c(in_c), .mode(in_mode), .acc(acc)
  );

  vmad_post #(.W(W), .SH_A(SH_A), .SH_B(SH_B)) u_post (
    .acc(acc), .scale(in_scale), .res_signed(res_signed),
    .sat_en(in_sat), .res(res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/vmad_unit_chk.sv
module vmad_unit_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_c,
  input logic [1:0]   in_mode,
  input logic [1:0]   in_scale,
  input logic         in_sat,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data
);
  logic acc_ok;
  assign acc_ok = in_valid && in_ready && (in_a == '0) && (in_scale == 2'd0) && !in_sat;

  // R5: zero product leaves C as the result
  a_r5_zero_product_passes_c: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && in_mode == 2'd0) |=> (out_data == $past(in_c)));

  // R6: negate-C mode with zero product
  a_r6_neg_c: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && in_mode == 2'd1) |=> (out_data == W'(~$past(in_c) + 1'b1)));

  // R6: plus-one mode with zero product
  a_r6_plus_one: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && in_mode == 2'd3) |=> (out_data == W'($past(in_c) + 1'b1)));

  // R12: accepted operation shows up next cycle
  a_r12_latency: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R12: stalled result is held
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

endmodule

bind vmad_unit vmad_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_c(in_c), .in_mode(in_mode), .in_scale(in_scale),
  .in_sat(in_sat), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/vmad_unit_tb.sv
`timescale 1ns/1ps
module vmad_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0, in_b = '0, in_c = '0;
  logic [15:0] in_imm = '0;
  logic        in_use_imm = 1'b0;
  logic [3:0]  in_asel = '0, in_bsel = '0;
  logic [1:0]  in_mode = '0, in_scale = '0;
  logic        in_sat = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit bp_on = 1'b0;
  bit in_fire;
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #2.5 clk = ~clk;

  vmad_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_c(in_c), .in_imm(in_imm),
    .in_use_imm(in_use_imm), .in_asel(in_asel), .in_bsel(in_bsel),
    .in_mode(in_mode), .in_scale(in_scale), .in_sat(in_sat),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // operand source per R1/R2
  function automatic logic [63:0] ext_op(input logic [31:0] x, input logic [3:0] s);
    logic [7:0]  b8;
    logic [15:0] h16;
    b8  = 8'(x >> (8 * s[1:0]));
    h16 = 16'(x >> (16 * s[0]));
    if (!s[2])      return s[3] ? {{56{b8[7]}}, b8} : {56'd0, b8};
    else if (!s[1]) return s[3] ? {{48{h16[15]}}, h16} : {48'd0, h16};
    else            return s[3] ? {{32{x[31]}}, x} : {32'd0, x};
  endfunction

  function automatic logic [31:0] model(input logic [31:0] a, b, c, input logic [15:0] imm,
      input logic ui, input logic [3:0] as, bs, input logic [1:0] m, sc, input logic st);
    logic [63:0] av, bv, p, s;
    logic [31:0] cc, hi, lo;
    logic rs;
    int sh;
    av = ext_op(a, as);
    bv = ui ? (bs[3] ? {{48{imm[15]}}, imm} : {48'd0, imm}) : ext_op(b, bs);
    p  = av * bv;
    if (m == 2'd2) p = 64'd0 - p;
    cc = (m == 2'd1) ? (32'd0 - c) : c;
    s  = p + {32'd0, cc};
    if (m == 2'd3) s = s + 64'd1;
    rs = (as[3:1] == 3'b111) || (bs[3:1] == 3'b111) || m == 2'd1 || m == 2'd2;
    sh = (sc == 2'd1) ? 7 : (sc == 2'd2) ? 15 : 0;
    s  = rs ? 64'($signed(s) >>> sh) : (s >> sh);
    hi = s[63:32];
    lo = s[31:0];
    if (!st) return lo;
    if (rs) begin
      if (hi != {32{lo[31]}}) return hi[31] ? 32'h8000_0000 : 32'h7FFF_FFFF;
      return lo;
    end
    if (hi != 32'd0) return hi[31] ? 32'd0 : 32'hFFFF_FFFF;
    return lo;
  endfunction

  // one cycle: called just after a falling edge, returns after the next one
  task automatic step();
    out_ready = bp_on ? (($urandom % 4) != 0) : 1'b1;
    #1;
    in_fire = in_valid && in_ready;
    if (out_valid) begin
      if (q_exp.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R12: actual %h expected none", out_data);
      end else if (!out_ready) begin
        check("R12 held", out_data, q_exp[0]);
      end else begin
        check(q_tag[0], out_data, q_exp[0]);
        void'(q_exp.pop_front());
        void'(q_tag.pop_front());
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [31:0] a, b, c, input logic [15:0] imm, input logic ui,
      input logic [3:0] as, bs, input logic [1:0] m, sc, input logic st,
      input logic [31:0] exp, input string tag);
    in_a = a; in_b = b; in_c = c; in_imm = imm; in_use_imm = ui;
    in_asel = as; in_bsel = bs; in_mode = m; in_scale = sc; in_sat = st;
    in_valid = 1'b1;
    do step(); while (!in_fire);
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 64 && q_exp.size() > 0; k++) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R13 out_valid", {31'd0, out_valid}, 32'd0);
    check("R13 in_ready", {31'd0, in_ready}, 32'd1);
    @(negedge clk);

    // R1: signed byte 3
    send(32'h80FF_7F01, 0, 0, 16'd1, 1, 4'b1011, 4'b0000, 0, 0, 0, 32'hFFFF_FF80, "R1 byte3");
    // R2: halfword 1 unsigned vs signed
    send(32'hBEEF_0000, 2, 0, 0, 0, 4'b0101, 4'b0110, 0, 0, 0, 32'h0001_7DDE, "R2 u16h1");
    send(32'hBEEF_0000, 2, 0, 0, 0, 4'b1101, 4'b0110, 0, 0, 0, 32'hFFFF_7DDE, "R2 s16h1");
    // R3: immediate extension, in_b ignored
    send(5, 32'h1234_5678, 0, 16'hFFFF, 1, 4'b0110, 4'b1000, 0, 0, 0, 32'hFFFF_FFFB, "R3 simm");
    send(5, 32'h1234_5678, 0, 16'hFFFF, 1, 4'b0110, 4'b0000, 0, 0, 0, 32'h0004_FFFB, "R3 uimm");
    // R4: mixed signedness reaches the upper word
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 4'b0110, 4'b1110, 0, 2, 0, 32'hFFFE_0000, "R4 mixed");
    // R5: carry from C into upper word
    send(32'hFFFF_FFFF, 1, 1, 0, 0, 4'b0110, 4'b0110, 0, 0, 1, 32'hFFFF_FFFF, "R5 carry sat");
    send(32'hFFFF_FFFF, 1, 1, 0, 0, 4'b0110, 4'b0110, 0, 0, 0, 32'h0000_0000, "R5 carry");
    // R6: modes
    send(0, 0, 1, 0, 0, 4'b0110, 4'b0110, 1, 0, 1, 32'h7FFF_FFFF, "R6 negc sat");
    send(3, 4, 0, 0, 0, 4'b0110, 4'b0110, 2, 0, 0, 32'hFFFF_FFF4, "R6 negprod");
    send(32'hFFFF_FFFF, 1, 0, 0, 0, 4'b0110, 4'b0110, 3, 0, 0, 32'h0000_0000, "R6 plus1");
    // R7 / R10: signedness of result picks the saturation rule
    send(32'h0000_00FF, 2, 0, 0, 0, 4'b1000, 4'b0000, 0, 0, 1, 32'h0000_0000, "R10 negative");
    send(32'h0000_00FF, 2, 0, 0, 0, 4'b1000, 4'b0000, 1, 0, 1, 32'hFFFF_FFFE, "R7 signed");
    // R8: scales and shift type
    send(32'h1234_5678, 32'h100, 0, 0, 0, 4'b0110, 4'b0110, 0, 1, 0, 32'h2468_ACF0, "R8 shr7");
    send(32'h1234_5678, 32'h100, 0, 0, 0, 4'b0110, 4'b0110, 0, 2, 0, 32'h0024_68AC, "R8 shr15");
    send(32'h1234_5678, 32'h100, 0, 0, 0, 4'b0110, 4'b0110, 0, 3, 0, 32'h3456_7800, "R8 none");
    send(32'h0000_8000, 4, 0, 0, 0, 4'b1100, 4'b0000, 0, 2, 1, 32'hFFFF_FFFF, "R8 logical");
    send(32'h0000_8000, 4, 0, 0, 0, 4'b1100, 4'b0000, 1, 2, 1, 32'hFFFF_FFFC, "R8 arith");
    // R9 / R11
    send(32'h7FFF_FFFF, 2, 0, 0, 0, 4'b1110, 4'b1110, 0, 0, 1, 32'h7FFF_FFFF, "R9 clamp");
    send(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 0, 0, 4'b0110, 4'b1110, 0, 0, 1, 32'h8000_0000, "R9 neg");
    send(32'h7FFF_FFFF, 2, 0, 0, 0, 4'b1110, 4'b1110, 0, 0, 0, 32'hFFFF_FFFE, "R11 wrap");
    drain();

    // sweep with random back-pressure
    bp_on = 1'b1;
    for (int as = 0; as < 16; as++)
      for (int bs = 0; bs < 16; bs++)
        for (int m = 0; m < 4; m++)
          for (int sc = 0; sc < 4; sc++)
            for (int cfg = 0; cfg < 4; cfg++)
              for (int pat = 0; pat < 2; pat++) begin
                logic [31:0] a, b, c, e;
                logic [15:0] imm;
                logic st, ui;
                string tg;
                st = cfg[0]; ui = cfg[1];
                a = $urandom; b = $urandom; c = $urandom; imm = 16'($urandom);
                if (pat == 1) begin
                  a = a | 32'h8080_8080; b = b | 32'h8080_8080; imm = imm | 16'h8000;
                end
                e = model(a, b, c, imm, ui, 4'(as), 4'(bs), 2'(m), 2'(sc), st);
                if (st) tg = "R9/R10 sweep";
                else if (sc != 0) tg = "R8 sweep";
                else if (m != 0) tg = "R6 sweep";
                else if (ui) tg = "R3 sweep";
                else tg = "R4 sweep";
                send(a, b, c, imm, ui, 4'(as), 4'(bs), 2'(m), 2'(sc), st, e, tg);
              end
    bp_on = 1'b0;
    drain();
    check("R12 drained", {31'd0, out_valid}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule